// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block keeps track of interrupt vectors for one processor core. The vector space is 256 entries wide and is held in three bit arrays: requests waiting for service, vectors now in service, and the trigger kind (level or edge) recorded for each vector. A vector is stored as bit (vector mod 32) of 32-bit word (vector / 32). Incoming fixed interrupts set a pending bit. A programmable task priority and the highest in-service vector together give a processor priority, and the highest pending vector is offered to the core only when its class beats that priority.

The core accepts the offered vector with a one-cycle acknowledge strobe, which moves the vector from pending to in service. When the handler finishes, the core pulses end-of-interrupt. The controller then retires the highest in-service vector and reports that vector together with its trigger kind, so a level-sensitive source can be rearmed. Processor priority and the offer are combinational from the stored state, so they follow every update on the next clock edge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all three vector arrays and the task priority are zero, no vector is offered, processor priority reads 0 and the retire pulse is low.
- R2: An accepted request sets the pending bit of its vector on the next edge. Among pending vectors, the one offered is the highest number, searched from word 7 down to word 0 and from the most significant bit of a word downward.
- R3: A pending vector is offered only when its value with the low 4 bits cleared is strictly greater than the processor priority. Vectors 0 to 15 are therefore never offered.
- R4: Processor priority equals the whole 8-bit task priority when task priority bits 7:4 are at least bits 7:4 of the highest in-service vector, taken as 0 when nothing is in service. Otherwise it equals that in-service vector with bits 3:0 cleared.
- R5: A task priority write keeps only bits 7:0 of the write data, visible from the next edge.
- R6: An acknowledge while a vector is offered sets that vector's in-service bit and clears its pending bit on the next edge. An acknowledge with nothing offered has no effect.
- R7: End-of-interrupt with something in service clears the highest in-service bit and its trigger bit. One cycle later the retire pulse is high for one cycle, with the retired vector and a level flag that is 1 if the vector was recorded as level (trigger bit 1) and 0 for edge.
- R8: End-of-interrupt with nothing in service changes nothing and gives no retire pulse.
- R9: A level request for a vector that is already pending is dropped and leaves its trigger bit unchanged. Any other accepted request records level as 1 or edge as 0 in the trigger bit, so an edge request overwrites an earlier level record.
- R10: Requests are ignored while either the hardware enable or the software enable is low.
- R11: A request and an acknowledge for the same vector in the same cycle leave that vector both in service and pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level triggered, 0 = edge |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 32 | Task priority write data (bits 7:0 kept) |
| ack | input | 1 | Core accepts the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| offer_valid | output | 1 | A vector is deliverable |
| offer_vec | output | 8 | Offered vector |
| ppr_o | output | 8 | Processor priority |
| tpr_o | output | 8 | Task priority |
| eoi_valid | output | 1 | One-cycle retire pulse |
| eoi_vec | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level triggered |

## Verification
The offer logic is tried with pending sets spread across different words and with pending vectors in the same class as, just below, and above the processor priority. This separates a wrong word scan, a wrong bit scan, and an off-by-one in the strict class comparison. Priority is driven by task values whose class lies above, equal to, and below the in-service class, and by nested in-service vectors, so that retire order and the fall-back from task to in-service priority are each visible. Edge-then-level, level-then-edge and level-then-level request pairs separate the drop rule from the trigger overwrite through the reported level flag.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
  parameter int N = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] q
);
  // set wins over clear on the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W  = $clog2(WORD_W),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int VEC_W  = IDX_W + WSEL_W
) (
  input  logic [WORDS*WORD_W-1:0] bits,
  output logic                    any,
  output logic [VEC_W-1:0]        top
);
  logic [WORDS-1:0]            word_nz;
  logic [WORDS-1:0][IDX_W-1:0] word_msb;

  function automatic logic [IDX_W-1:0] msb_of(input logic [WORD_W-1:0] w);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W; i++) if (w[i]) r = IDX_W'(i);
    return r;
  endfunction

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign word_nz[g]  = |bits[g*WORD_W +: WORD_W];
    assign word_msb[g] = msb_of(bits[g*WORD_W +: WORD_W]);
  end

  // later (higher) words overwrite earlier ones: top word wins
  always_comb begin
    top = '0;
    for (int w = 0; w < WORDS; w++)
      if (word_nz[w]) top = {WSEL_W'(w), word_msb[w]};
  end

  assign any = |word_nz;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int WORDS    = 8,
  parameter int WORD_W   = 32,
  parameter int CLS_W    = 4,
  parameter int TPR_IN_W = 32,
  localparam int NUM_VEC = WORDS * WORD_W,
  localparam int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_en,
  input  logic                sw_en,
  input  logic                req_valid,
  input  logic [VEC_W-1:0]    req_vec,
  input  logic                req_level,
  input  logic                tpr_we,
  input  logic [TPR_IN_W-1:0] tpr_wdata,
  input  logic                ack,
  input  logic                eoi,
  output logic                offer_valid,
  output logic [VEC_W-1:0]    offer_vec,
  output logic [VEC_W-1:0]    ppr_o,
  output logic [VEC_W-1:0]    tpr_o,
  output logic                eoi_valid,
  output logic [VEC_W-1:0]    eoi_vec,
  output logic                eoi_level
);
  localparam int SUB_W = VEC_W - CLS_W;

  function automatic logic [VEC_W-1:0] vec_bit(input logic [VEC_W-1:0] v);
    return VEC_W'(0) | (NUM_VEC'(1) << v);
  endfunction

  function automatic logic [NUM_VEC-1:0] onehot(input logic [VEC_W-1:0] v);
    return NUM_VEC'(1) << v;
  endfunction

  function automatic logic [VEC_W-1:0] ppr_calc(input logic [VEC_W-1:0] tpr,
                                                input logic             isr_any,
                                                input logic [VEC_W-1:0] isr_top);
    logic [VEC_W-1:0] isrv;
    isrv = isr_any ? isr_top : '0;
    if (tpr[VEC_W-1 -: CLS_W] >= isrv[VEC_W-1 -: CLS_W]) return tpr;
    return {isrv[VEC_W-1 -: CLS_W], {SUB_W{1'b0}}};
  endfunction

  function automatic logic beats(input logic [VEC_W-1:0] cand,
                                 input logic [VEC_W-1:0] ppr);
    return {cand[VEC_W-1 -: CLS_W], {SUB_W{1'b0}}} > ppr;
  endfunction

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_set, irr_clr, isr_set, isr_clr, tmr_set, tmr_clr;
  logic [VEC_W-1:0]   tpr_q, irr_top, isr_top;
  logic               irr_any, isr_any;
  logic               tpr_hi_unused;

  // named internal events
  logic req_open, req_take, req_drop, ack_take, eoi_take;
  trig_e retire_trig;

  irq_prio_find #(.WORDS(WORDS), .WORD_W(WORD_W)) u_find_irr (
    .bits(irr_q), .any(irr_any), .top(irr_top));
  irq_prio_find #(.WORDS(WORDS), .WORD_W(WORD_W)) u_find_isr (
    .bits(isr_q), .any(isr_any), .top(isr_top));

  assign ppr_o       = ppr_calc(tpr_q, isr_any, isr_top);
  assign offer_valid = irr_any && beats(irr_top, ppr_o);
  assign offer_vec   = irr_top;
  assign tpr_o       = tpr_q;

  assign req_open = req_valid && hw_en && sw_en;
  assign req_drop = req_open && req_level && irr_q[req_vec];
  assign req_take = req_open && !req_drop;
  assign ack_take = ack && offer_valid;
  assign eoi_take = eoi && isr_any;
  assign retire_trig = trig_e'(tmr_q[isr_top]);

  always_comb begin
    irr_set = req_take ? onehot(req_vec) : '0;
    irr_clr = ack_take ? onehot(offer_vec) : '0;
    isr_set = ack_take ? onehot(offer_vec) : '0;
    isr_clr = eoi_take ? onehot(isr_top) : '0;
    tmr_set = (req_take && req_level) ? onehot(req_vec) : '0;
    tmr_clr = ((req_take && !req_level) ? onehot(req_vec) : '0)
            | (eoi_take ? onehot(isr_top) : '0);
  end

  irq_vec_reg #(.N(NUM_VEC)) u_irr (
    .clk(clk), .rst_n(rst_n), .set_mask(irr_set), .clr_mask(irr_clr), .q(irr_q));
  irq_vec_reg #(.N(NUM_VEC)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_mask(isr_set), .clr_mask(isr_clr), .q(isr_q));
  irq_vec_reg #(.N(NUM_VEC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .set_mask(tmr_set), .clr_mask(tmr_clr), .q(tmr_q));

  assign tpr_hi_unused = ^tpr_wdata[TPR_IN_W-1:VEC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q     <= '0;
      eoi_valid <= 1'b0;
      eoi_vec   <= '0;
      eoi_level <= 1'b0;
    end else begin
      if (tpr_we) tpr_q <= tpr_wdata[VEC_W-1:0];
      eoi_valid <= eoi_take;
      if (eoi_take) begin
        eoi_vec   <= isr_top;
        eoi_level <= (retire_trig == TRIG_LEVEL);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8,
  parameter int CLS_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hw_en,
  input logic               sw_en,
  input logic               req_valid,
  input logic [VEC_W-1:0]   req_vec,
  input logic               req_level,
  input logic               tpr_we,
  input logic [VEC_W-1:0]   tpr_wlow,
  input logic               ack,
  input logic               eoi,
  input logic               offer_valid,
  input logic [VEC_W-1:0]   offer_vec,
  input logic [VEC_W-1:0]   ppr_o,
  input logic [VEC_W-1:0]   tpr_o,
  input logic               eoi_valid,
  input logic [VEC_W-1:0]   eoi_vec,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q,
  input logic [NUM_VEC-1:0] tmr_q
);
  // R3
  offer_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_vec[VEC_W-1 -: CLS_W] > ppr_o[VEC_W-1 -: CLS_W]));

  // R4
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_o >= tpr_o);

  // R5
  tpr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_we |=> (tpr_o == $past(tpr_wlow)));

  // R6
  ack_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && offer_valid && !(req_valid && req_vec == offer_vec))
      |=> (isr_q[$past(offer_vec)] && !irr_q[$past(offer_vec)]));

  // R7
  eoi_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !isr_q[eoi_vec]);

  // R8
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_q == '0 && !ack) |=> (!eoi_valid && isr_q == '0));

  // R9
  level_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hw_en && sw_en && req_level && irr_q[req_vec] && !eoi)
      |=> $stable(tmr_q));

  // R10
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hw_en && sw_en) && !ack) |=> $stable(irr_q));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .CLS_W(CLS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
  .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
  .tpr_we(tpr_we), .tpr_wlow(tpr_wdata[VEC_W-1:0]),
  .ack(ack), .eoi(eoi), .offer_valid(offer_valid), .offer_vec(offer_vec),
  .ppr_o(ppr_o), .tpr_o(tpr_o), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
  .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_en = 1'b1, sw_en = 1'b1;
  logic        req_valid = 1'b0, req_level = 1'b0;
  logic [7:0]  req_vec = '0;
  logic        tpr_we = 1'b0;
  logic [31:0] tpr_wdata = '0;
  logic        ack = 1'b0, eoi = 1'b0;
  logic        offer_valid, eoi_valid, eoi_level;
  logic [7:0]  offer_vec, ppr_o, tpr_o, eoi_vec;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] vec; logic lvl; string tag; } retire_t;
  retire_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
    .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ack(ack), .eoi(eoi),
    .offer_valid(offer_valid), .offer_vec(offer_vec), .ppr_o(ppr_o),
    .tpr_o(tpr_o), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .eoi_level(eoi_level));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic req(input logic [7:0] v, input logic lvl);
    req_valid = 1'b1; req_vec = v; req_level = lvl;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic ack_it();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic tpr_wr(input logic [31:0] d);
    tpr_we = 1'b1; tpr_wdata = d; tick(); tpr_we = 1'b0;
  endtask

  // driver: pushes the expected retirement, then strobes end-of-interrupt
  task automatic eoi_it(input bit expect_any, input logic [7:0] v,
                        input logic lvl, input string tag);
    retire_t e;
    if (expect_any) begin
      e.vec = v; e.lvl = lvl; e.tag = tag;
      exp_q.push_back(e);
    end
    eoi = 1'b1; tick(); eoi = 1'b0;
  endtask

  task automatic offer_is(input string tag, input bit v, input logic [7:0] vec);
    chk({tag, " offer_valid"}, int'(offer_valid), int'(v));
    if (v) chk({tag, " offer_vec"}, int'(offer_vec), int'(vec));
  endtask

  // monitor: every retire pulse pops and compares the scoreboard
  always @(negedge clk) begin
    if (rst_n && eoi_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected retire: actual %0h expected none", eoi_vec);
      end else begin
        retire_t e;
        e = exp_q.pop_front();
        chk({e.tag, " retired vector"}, int'(eoi_vec), int'(e.vec));
        chk({e.tag, " retired level"}, int'(eoi_level), int'(e.lvl));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    offer_is("R1 reset", 1'b0, 8'h00);
    chk("R1 reset ppr", int'(ppr_o), 0);
    chk("R1 reset tpr", int'(tpr_o), 0);
    chk("R1 reset retire", int'(eoi_valid), 0);

    // R3: class 0 never offered; R2: highest across words
    req(8'h0F, 1'b0);
    offer_is("R3 class0", 1'b0, 8'h00);
    req(8'h23, 1'b0);
    offer_is("R2 word1", 1'b1, 8'h23);
    req(8'h91, 1'b0);
    offer_is("R2 word4", 1'b1, 8'h91);
    req(8'h9F, 1'b0);
    offer_is("R2 msb in word", 1'b1, 8'h9F);

    // R6 / R4 / R3
    ack_it();
    chk("R4 ppr from isr", int'(ppr_o), 8'h90);
    offer_is("R3 same class blocked", 1'b0, 8'h00);
    tpr_wr(32'hFFFF_FFA5);
    chk("R5 tpr low byte", int'(tpr_o), 8'hA5);
    chk("R4 ppr from tpr", int'(ppr_o), 8'hA5);
    tpr_wr(32'h0000_0032);
    chk("R4 ppr back to isr class", int'(ppr_o), 8'h90);

    // R7 retire
    eoi_it(1'b1, 8'h9F, 1'b0, "R7 first");
    chk("R7 ppr after retire", int'(ppr_o), 8'h32);
    offer_is("R7 next offer", 1'b1, 8'h91);
    ack_it();
    offer_is("R3 lower class blocked", 1'b0, 8'h00);
    eoi_it(1'b1, 8'h91, 1'b0, "R7 second");
    offer_is("R3 class below tpr", 1'b0, 8'h00);
    tpr_wr(32'h10);
    offer_is("R3 class above tpr", 1'b1, 8'h23);
    tpr_wr(32'h0);
    ack_it();
    eoi_it(1'b1, 8'h23, 1'b0, "R7 third");

    // R8
    eoi_it(1'b0, 8'h00, 1'b0, "R8");
    chk("R8 no retire pulse", int'(eoi_valid), 0);
    chk("R8 ppr unchanged", int'(ppr_o), 0);

    // R9 trigger recording
    req(8'h40, 1'b0); req(8'h40, 1'b1);
    ack_it(); eoi_it(1'b1, 8'h40, 1'b0, "R9 level dup dropped");
    req(8'h41, 1'b1);
    ack_it(); eoi_it(1'b1, 8'h41, 1'b1, "R9 level kept");
    req(8'h42, 1'b1); req(8'h42, 1'b0);
    ack_it(); eoi_it(1'b1, 8'h42, 1'b0, "R9 edge overwrites");
    req(8'h43, 1'b1); req(8'h43, 1'b1);
    ack_it();
    offer_is("R9 single pending", 1'b0, 8'h00);
    eoi_it(1'b1, 8'h43, 1'b1, "R9 level twice");

    // R7 nesting order
    req(8'h50, 1'b0); ack_it();
    req(8'h70, 1'b0); req(8'h21, 1'b0);
    offer_is("R3 nested higher", 1'b1, 8'h70);
    ack_it();
    chk("R4 nested ppr", int'(ppr_o), 8'h70);
    eoi_it(1'b1, 8'h70, 1'b0, "R7 nested top");
    chk("R4 ppr after nested retire", int'(ppr_o), 8'h50);
    eoi_it(1'b1, 8'h50, 1'b0, "R7 nested lower");
    offer_is("R2 remaining", 1'b1, 8'h21);
    ack_it(); eoi_it(1'b1, 8'h21, 1'b0, "R7 remaining");

    // R6 ack without offer
    ack_it();
    eoi_it(1'b0, 8'h00, 1'b0, "R6 idle ack");
    chk("R6 idle ack no retire", int'(eoi_valid), 0);

    // R10
    hw_en = 1'b0; req(8'hC0, 1'b0);
    offer_is("R10 hw disabled", 1'b0, 8'h00);
    hw_en = 1'b1; tick();
    offer_is("R10 hw re-enabled", 1'b0, 8'h00);
    sw_en = 1'b0; req(8'hC1, 1'b0);
    sw_en = 1'b1; tick();
    offer_is("R10 sw disabled", 1'b0, 8'h00);

    // R11
    req(8'h60, 1'b0);
    offer_is("R11 offered", 1'b1, 8'h60);
    req_valid = 1'b1; req_vec = 8'h60; req_level = 1'b0; ack = 1'b1;
    tick();
    req_valid = 1'b0; ack = 1'b0;
    chk("R11 ppr", int'(ppr_o), 8'h60);
    offer_is("R11 blocked", 1'b0, 8'h00);
    eoi_it(1'b1, 8'h60, 1'b0, "R11 first");
    offer_is("R11 still pending", 1'b1, 8'h60);
    ack_it(); eoi_it(1'b1, 8'h60, 1'b0, "R11 second");

    repeat (3) tick();
    chk("R7 all retirements seen", exp_q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule